// File: doc/BRIEF.md
# Playback Sample Buffer with Byte-Credit Drain

This block sits on the playback path between a sample producer and a downstream consumer. The producer pushes 32-bit stereo samples, left channel in the upper 16 bits and right in the lower 16 bits. They land in an on-chip store that holds up to `DEPTH` samples. The consumer tells the block how much room it has by pulsing a grant, given in bytes. The block keeps that figure as a signed byte credit. Each sample written costs 4 bytes of credit.

The buffer is drained to the consumer in two cases: the store becomes full, or a write brings the credit to zero or below. The drain is a valid/ready stream of one sample per beat, sent in write order. A grant no larger than what is already buffered has two effects. The buffer is cut back to the granted number of samples and the rest is dropped. The credit is cleared and the shortened buffer drains at once. A larger grant only sets the credit to the remaining room. The producer sees the current credit in samples (credit divided by 4, floored at zero) as a data-request count. While a drain is in progress the producer's ready signal stays low.

Top module: `pbuf_credit_flush`

## Requirements
- R1: After reset `wr_ready` is 1, `drain_valid` is 0 and `req_samples` is 0; the byte credit and the fill index are both zero.
- R2: Samples leave on the drain port in exactly the order they were written, with their 32-bit values unchanged.
- R3: Each accepted write lowers the byte credit by 4, so `req_samples` falls by one.
- R4: A write that leaves the credit at zero or below starts a drain of every buffered sample, including that write.
- R5: The write that fills the store to `DEPTH` samples starts a drain of all `DEPTH` samples, whatever credit remains.
- R6: A grant of F bytes with B samples buffered and B < floor(F/4) sets the credit to (floor(F/4) - B) * 4 bytes and starts no drain.
- R7: A grant of F bytes with B >= floor(F/4) drains only the first floor(F/4) buffered samples, drops the rest and sets the credit to zero.
- R8: While a drain is in progress `wr_ready` is 0, and any grant that arrives is ignored: it does not change the credit.
- R9: While `drain_valid` is 1 and `drain_ready` is 0, `drain_valid` stays 1 and `drain_data` holds its value.
- R10: After a drain completes the buffer is empty. A grant of 0 bytes on an empty buffer produces no drain beat and leaves the credit at zero.
- R11: Bits [1:0] of `grant_bytes` are ignored; grants count whole 4-byte samples.
- R12: A grant and a write offered in the same cycle: the grant is taken and the write is refused (`wr_ready` is 0 in that cycle).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Producer offers a sample |
| wr_data | input | 32 | Sample, left in [31:16], right in [15:0] |
| wr_ready | output | 1 | Block accepts the offered sample this cycle |
| grant_valid | input | 1 | One-cycle pulse carrying a consumer grant |
| grant_bytes | input | $clog2(DEPTH*4)+1 | Free space at the consumer, in bytes |
| drain_valid | output | 1 | Drain beat is available |
| drain_data | output | 32 | Drained sample |
| drain_ready | input | 1 | Consumer takes the drain beat |
| req_samples | output | $clog2(DEPTH*4)-1 | Positive credit in samples, otherwise 0 |

## Verification
The assertions rely on a few conditions on the inputs:
- The producer holds data only under the valid/ready rule.
- Grants arrive as single-cycle pulses no larger than twice the store size in bytes.
- The consumer may lower `drain_ready` at any time.

The stimulus keeps to these conditions. Writes are offered only after `wr_ready` is seen high. Each grant is a single-cycle pulse. `drain_ready` is held high except in one deliberate back-pressure window. The simultaneous grant-and-write case is offered on purpose, to exercise the priority rule, and is not treated as a protocol violation.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;
  typedef enum logic [0:0] {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } pbuf_state_t;
endpackage

// File: rtl/pbuf_store.sv
module pbuf_store #(
  parameter int DEPTH = 1024,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // single write port, registered read port: maps onto a simple dual-port RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pbuf_credit.sv
module pbuf_credit #(
  parameter int GW_W   = 11,
  parameter int IDX_W  = 11,
  parameter int CRED_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             grant_take,
  input  logic [GW_W-1:0]  grant_words,
  input  logic             wr_fire,
  input  logic [IDX_W-1:0] fill_words,
  output logic             trunc,
  output logic             low_credit,
  output logic [GW_W-1:0]  req_samples
);
  logic signed [CRED_W-1:0] credit, credit_nxt;
  logic [CRED_W-1:0] gx, fx;

  assign gx         = CRED_W'(grant_words);
  assign fx         = CRED_W'(fill_words);
  assign trunc      = (fx >= gx);
  // the next write will take the credit to zero or below
  assign low_credit = (credit <= CRED_W'(4));

  always_comb begin
    credit_nxt = credit;
    if (grant_take) begin
      if (trunc) credit_nxt = '0;
      else       credit_nxt = signed'((gx - fx) << 2);
    end else if (wr_fire) begin
      credit_nxt = credit - CRED_W'(4);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credit      <= '0;
      req_samples <= '0;
    end else begin
      credit      <= credit_nxt;
      req_samples <= (credit_nxt > 0) ? GW_W'(credit_nxt >>> 2) : '0;
    end
  end

  assert_grant_req_R6: assert property (@(posedge clk) disable iff (rst)
    (grant_take && !trunc) |=> (req_samples == $past(GW_W'(grant_words) - GW_W'(fill_words))));
endmodule

// File: rtl/pbuf_credit_flush.sv
module pbuf_credit_flush
  import pbuf_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int SAMPLE_W = 32,
  localparam int CAP_BYTES = DEPTH * 4,
  localparam int GRANT_W   = $clog2(CAP_BYTES) + 1,
  localparam int GW_W      = GRANT_W - 2,
  localparam int IDX_W     = $clog2(DEPTH) + 1,
  localparam int AW        = $clog2(DEPTH),
  localparam int CRED_W    = GRANT_W + 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_data,
  output logic                wr_ready,
  input  logic                grant_valid,
  input  logic [GRANT_W-1:0]  grant_bytes,
  output logic                drain_valid,
  output logic [SAMPLE_W-1:0] drain_data,
  input  logic                drain_ready,
  output logic [GW_W-1:0]     req_samples
);
  pbuf_state_t      state;
  logic [IDX_W-1:0] idx, cnt, rd_ptr;
  logic [GW_W-1:0]  gw;
  logic             wr_fire, grant_take, slot_free, load, full_next;
  logic             trunc, low_credit;

  assign gw         = grant_bytes[GRANT_W-1:2];
  assign wr_ready   = (state == ST_FILL) && !grant_valid;
  assign wr_fire    = wr_valid && wr_ready;
  assign grant_take = grant_valid && (state == ST_FILL);
  assign slot_free  = !drain_valid || drain_ready;
  assign load       = (state == ST_DRAIN) && (rd_ptr != cnt) && slot_free;
  assign full_next  = (idx == IDX_W'(DEPTH - 1));

  pbuf_store #(.DEPTH(DEPTH), .W(SAMPLE_W)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr (idx[AW-1:0]),
    .wdata (wr_data),
    .re    (load),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (drain_data)
  );

  pbuf_credit #(.GW_W(GW_W), .IDX_W(IDX_W), .CRED_W(CRED_W)) u_credit (
    .clk         (clk),
    .rst         (rst),
    .grant_take  (grant_take),
    .grant_words (gw),
    .wr_fire     (wr_fire),
    .fill_words  (idx),
    .trunc       (trunc),
    .low_credit  (low_credit),
    .req_samples (req_samples)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FILL;
      idx         <= '0;
      cnt         <= '0;
      rd_ptr      <= '0;
      drain_valid <= 1'b0;
    end else begin
      case (state)
        ST_FILL: begin
          if (grant_take && trunc) begin
            if (gw == '0) begin
              idx <= '0;
            end else begin
              state  <= ST_DRAIN;
              cnt    <= IDX_W'(gw);
              rd_ptr <= '0;
            end
          end else if (wr_fire) begin
            if (full_next || low_credit) begin
              state  <= ST_DRAIN;
              cnt    <= idx + 1'b1;
              rd_ptr <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          if (load) begin
            rd_ptr      <= rd_ptr + 1'b1;
            drain_valid <= 1'b1;
          end else if (drain_ready) begin
            drain_valid <= 1'b0;
          end
          if ((rd_ptr == cnt) && slot_free) begin
            state <= ST_FILL;
            idx   <= '0;
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (drain_valid && !drain_ready) |=> (drain_valid && $stable(drain_data)));
  assert_no_accept_drain_R8: assert property (@(posedge clk) disable iff (rst)
    drain_valid |-> !wr_ready);
  assert_flush_on_credit_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && low_credit) |=> (state == ST_DRAIN));
  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (idx < IDX_W'(DEPTH)) && (rd_ptr <= cnt));
endmodule

// File: tb/test_pbuf_credit_flush.sv
`timescale 1ns/1ps
module test_pbuf_credit_flush;
  localparam int DEPTH = 1024;
  localparam int GRANT_W = $clog2(DEPTH*4) + 1;
  localparam int GW_W = GRANT_W - 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [31:0] wr_data = '0;
  logic wr_ready;
  logic grant_valid = 1'b0;
  logic [GRANT_W-1:0] grant_bytes = '0;
  logic drain_valid;
  logic [31:0] drain_data;
  logic drain_ready = 1'b1;
  logic [GW_W-1:0] req_samples;

  always #2 clk = ~clk;  // 250 MHz

  pbuf_credit_flush #(.DEPTH(DEPTH)) i_pbuf_credit_flush (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .grant_valid(grant_valid), .grant_bytes(grant_bytes),
    .drain_valid(drain_valid), .drain_data(drain_data), .drain_ready(drain_ready),
    .req_samples(req_samples)
  );

  int nvec = 0, nerr = 0, wcnt = 0, ncap = 0;
  logic [31:0] cap [2048];

  // kind (1 = grant, 0 = writes), argument, expected req_samples, expected drained total
  localparam logic [48:0] VEC [11] = '{
    {1'b1, 16'd40, 16'd10, 16'd0},  // R6
    {1'b0, 16'd3,  16'd7,  16'd0},  // R3
    {1'b1, 16'd20, 16'd2,  16'd0},  // R6
    {1'b0, 16'd1,  16'd1,  16'd0},  // R3
    {1'b0, 16'd1,  16'd0,  16'd5},  // R4
    {1'b1, 16'd23, 16'd5,  16'd5},  // R11
    {1'b0, 16'd2,  16'd3,  16'd5},  // R3
    {1'b1, 16'd4,  16'd0,  16'd6},  // R7
    {1'b1, 16'd0,  16'd0,  16'd6},  // R10
    {1'b1, 16'd8,  16'd2,  16'd6},  // R6
    {1'b0, 16'd2,  16'd0,  16'd8}   // R4
  };

  function automatic logic [31:0] sample_of(int k);
    return {k[15:0], ~k[15:0]};
  endfunction

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_write(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!wr_ready) @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = sample_of(wcnt);
      @(negedge clk);
      wr_valid = 1'b0;
      wcnt++;
    end
  endtask

  task automatic do_grant(int b);
    @(negedge clk);
    grant_valid = 1'b1;
    grant_bytes = GRANT_W'(b);
    @(negedge clk);
    grant_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    #1;
    if (drain_valid && drain_ready) begin
      cap[ncap] = drain_data;
      ncap++;
    end
  end

  initial begin
    #(4ns * 150000);
    nerr++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 wr_ready", int'(wr_ready), 1);
    chk("R1 drain_valid", int'(drain_valid), 0);
    chk("R1 req_samples", int'(req_samples), 0);

    for (int v = 0; v < 11; v++) begin
      if (VEC[v][48]) do_grant(int'(VEC[v][47:32]));
      else            do_write(int'(VEC[v][47:32]));
      repeat (20) @(negedge clk);
      chk($sformatf("vector %0d req (R3/R4/R6/R7/R10/R11)", v), int'(req_samples), int'(VEC[v][31:16]));
      chk($sformatf("vector %0d drained", v), ncap, int'(VEC[v][15:0]));
    end

    // R2 / R7: order and truncation (write 6 was dropped)
    chk("R2 cap0", int'(cap[0]), int'(sample_of(0)));
    chk("R2 cap4", int'(cap[4]), int'(sample_of(4)));
    chk("R7 cap5", int'(cap[5]), int'(sample_of(5)));
    chk("R2 cap6", int'(cap[6]), int'(sample_of(7)));
    chk("R2 cap7", int'(cap[7]), int'(sample_of(8)));

    // R9 / R8: back-pressure during a drain
    drain_ready = 1'b0;
    do_grant(8);
    do_write(2);
    repeat (5) @(negedge clk);
    chk("R9 drain_valid", int'(drain_valid), 1);
    chk("R8 wr_ready low", int'(wr_ready), 0);
    chk("R9 data", int'(drain_data), int'(sample_of(9)));
    held = drain_data;
    do_grant(400);
    repeat (3) @(negedge clk);
    chk("R9 stable", int'(drain_data), int'(held));
    drain_ready = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 drained", ncap, 10);
    chk("R8 grant ignored", int'(req_samples), 0);
    chk("R2 cap9", int'(cap[9]), int'(sample_of(10)));

    // R12: grant wins over a simultaneous write
    @(negedge clk);
    grant_valid = 1'b1;
    grant_bytes = GRANT_W'(12);
    wr_valid    = 1'b1;
    wr_data     = 32'hDEADBEEF;
    #1;
    chk("R12 wr_ready", int'(wr_ready), 0);
    @(negedge clk);
    grant_valid = 1'b0;
    wr_valid    = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 req", int'(req_samples), 3);
    chk("R12 no drain", ncap, 10);

    // R5: full store drains regardless of credit
    do_grant(8188);
    repeat (3) @(negedge clk);
    chk("R6 big grant", int'(req_samples), 2047);
    do_write(DEPTH);
    repeat (1100) @(negedge clk);
    chk("R5 drained", ncap, 10 + DEPTH);
    chk("R5 req", int'(req_samples), 2047 - DEPTH);
    chk("R5 last", int'(cap[10 + DEPTH - 1]), int'(sample_of(wcnt - 1)));
    chk("R10 idle", int'(drain_valid), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule